// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers level-sensitive interrupt sources from peripherals and groups them into five banks of 32 sources each. Every source has a status latch. The latch captures a high level and keeps it until software clears it by writing a one to that bit. Each bank also has an enable mask. The pending view of a bank is its status ANDed with its enable mask. That view drives one CPU request line per bank, with bank n on line n.

A highest-bit encoder runs on each bank's pending view. It tells the dispatcher which source to serve: the highest-numbered pending bit wins. A valid flag goes with the index. Software reaches the registers over a simple synchronous bus with a word address, a write strobe, write data and registered read data.

Top module: `banked_irq_ctrl`

## Requirements
- R1: There are five banks of 32 sources. Source k of bank n is bit n*32+k of `src_i`. A cycle in which that source is high sets its status bit at the next clock edge.
- R2: Bank n uses word addresses 4n (status), 4n+1 (enable) and 4n+2 (pending = status AND enable). Read data for the address presented at one clock edge appears on `bus_rdata` after that edge.
- R3: A write to a status address clears every status bit whose write-data bit is 1. Bits written as 0 keep their value. If a source is high in the same cycle as its clear, the bit stays set.
- R4: A write to an enable address loads all 32 bits. Reading that address returns the stored value.
- R5: A read of the pending address returns status AND enable for that bank.
- R6: `cpu_irq_o[n]` is the OR of bank n's pending bits, registered once. It is high in the cycle after any pending bit is set.
- R7: `hi_idx_o[5n+4:5n]` holds the number of the highest pending bit of bank n, registered once, and `hi_vld_o[n]` is high when any bit is pending. When nothing is pending, the valid flag is 0 and the index is 0.
- R8: A synchronous active-high `rst` clears all status and enable bits, the request lines, the encoder outputs and the read data.
- R9: Addresses with low bits 3, and addresses 20 to 31 (banks 5 to 7), read as zero. Writes to them change no state.
- R10: A write to a pending address changes neither status nor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 160 | Level interrupt sources, 32 per bank |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq_o | output | 5 | Per-bank CPU request lines |
| hi_idx_o | output | 25 | Per-bank highest pending bit number, 5 bits each |
| hi_vld_o | output | 5 | Per-bank encoder valid flags |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check counts. They also assume that the bus address and write strobe are stable around each rising edge. The bench changes every input only on the falling clock edge and keeps reset asserted across several edges at the start and in the middle of the run. The sources are driven as plain levels, with no assumed relation to bus writes. This lets the stimulus put a clear and an active source in the same cycle and aim writes at unmapped and read-only addresses.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_PEND = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_msb_enc.sv
`timescale 1ns/1ps
module irqc_msb_enc #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          vld
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
    vld = |vec;
  end
endmodule

// File: rtl/irqc_bank.sv
`timescale 1ns/1ps
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  src,
  input  logic          wr,
  input  reg_sel_e      sel,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  stat,
  output logic [W-1:0]  en,
  output logic [W-1:0]  pend,
  output logic          irq_q,
  output logic [IW-1:0] idx_q,
  output logic          vld_q
);
  logic [W-1:0]  clr;
  logic [IW-1:0] idx_c;
  logic          vld_c;

  assign clr  = (wr && sel == REG_STAT) ? wdata : '0;
  assign pend = stat & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr) | src;
      if (wr && sel == REG_EN) en <= wdata;
    end
  end

  irqc_msb_enc #(.W(W), .IW(IW)) u_enc (
    .vec (pend),
    .idx (idx_c),
    .vld (vld_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      irq_q <= |pend;
      idx_q <= idx_c;
      vld_q <= vld_c;
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned IDX_W     = $clog2(BANK_W)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic [NUM_BANKS-1:0]        cpu_irq_o,
  output logic [NUM_BANKS*IDX_W-1:0]  hi_idx_o,
  output logic [NUM_BANKS-1:0]        hi_vld_o
);
  localparam int unsigned BSEL_W = ADDR_W - 2;

  logic [BSEL_W-1:0] bank_sel;
  reg_sel_e          reg_sel;
  logic [BANK_W-1:0] stat_a [NUM_BANKS];
  logic [BANK_W-1:0] en_a   [NUM_BANKS];
  logic [BANK_W-1:0] pend_a [NUM_BANKS];
  logic [BANK_W-1:0] rd_c;

  assign bank_sel = bus_addr[ADDR_W-1:2];
  assign reg_sel  = reg_sel_e'(bus_addr[1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bank_sel == BSEL_W'(b));
    irqc_bank #(.W(BANK_W), .IW(IDX_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .src   (src_i[b*BANK_W +: BANK_W]),
      .wr    (hit),
      .sel   (reg_sel),
      .wdata (bus_wdata),
      .stat  (stat_a[b]),
      .en    (en_a[b]),
      .pend  (pend_a[b]),
      .irq_q (cpu_irq_o[b]),
      .idx_q (hi_idx_o[b*IDX_W +: IDX_W]),
      .vld_q (hi_vld_o[b])
    );
  end

  always_comb begin
    rd_c = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        case (reg_sel)
          REG_STAT: rd_c = stat_a[b];
          REG_EN:   rd_c = en_a[b];
          REG_PEND: rd_c = pend_a[b];
          default:  rd_c = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_c;
  end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned IDX_W     = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [BANK_W-1:0]          bus_rdata,
  input logic [NUM_BANKS-1:0]       cpu_irq_o,
  input logic [NUM_BANKS*IDX_W-1:0] hi_idx_o,
  input logic [NUM_BANKS-1:0]       hi_vld_o
);
  logic unmapped;
  assign unmapped = (int'(bus_addr[ADDR_W-1:2]) >= NUM_BANKS) || (bus_addr[1:0] == 2'd3);

  AST_IRQ_EQ_VLD: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o == hi_vld_o); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (cpu_irq_o == '0 && hi_vld_o == '0 && bus_rdata == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> bus_rdata == '0); // R9

  always @(posedge clk) begin
    if (!rst) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (!hi_vld_o[b]) begin
          AST_IDLE_IDX_ZERO: assert (hi_idx_o[b*IDX_W +: IDX_W] == '0); // R7
        end
      end
    end
  end
endmodule

bind banked_irq_ctrl irqc_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .cpu_irq_o (cpu_irq_o),
  .hi_idx_o  (hi_idx_o),
  .hi_vld_o  (hi_vld_o)
);

// File: tb/sim_banked_irq_ctrl.sv
`timescale 1ns/1ps
module sim_banked_irq_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [159:0] src = '0;
  logic [4:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [4:0]   irq;
  logic [24:0]  hidx;
  logic [4:0]   hvld;

  int checks = 0;
  int fails  = 0;
  string tag = "R8";

  logic [31:0] m_st [5];
  logic [31:0] m_en [5];
  logic [31:0] e_rd;
  logic [4:0]  e_irq;
  logic [24:0] e_idx;
  logic [4:0]  e_vld;

  always #5 clk = ~clk;

  banked_irq_ctrl u0 (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .cpu_irq_o(irq),
    .hi_idx_o(hidx), .hi_vld_o(hvld)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: update the reference model at the edge, compare on the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      for (int b = 0; b < 5; b++) begin m_st[b] = '0; m_en[b] = '0; end
      e_rd = '0; e_irq = '0; e_idx = '0; e_vld = '0;
    end else begin
      int bi;
      int r;
      bi = int'(addr) / 4;
      r  = int'(addr) % 4;
      e_rd = 0;
      if (bi < 5 && r == 0) e_rd = m_st[bi];
      if (bi < 5 && r == 1) e_rd = m_en[bi];
      if (bi < 5 && r == 2) e_rd = m_st[bi] & m_en[bi];
      for (int b = 0; b < 5; b++) begin
        logic [31:0] p;
        int top;
        p = m_st[b] & m_en[b];
        top = -1;
        for (int k = 31; k >= 0; k--) if (p[k] && top < 0) top = k;
        e_irq[b] = (p != 0);
        e_vld[b] = (top >= 0);
        e_idx[b*5 +: 5] = (top >= 0) ? 5'(top) : 5'd0;
      end
      for (int b = 0; b < 5; b++) begin
        logic [31:0] ack;
        ack = (we && bi == b && r == 0) ? wdata : 32'd0;
        m_st[b] = (m_st[b] & ~ack) | src[b*32 +: 32];
        if (we && bi == b && r == 1) m_en[b] = wdata;
      end
    end
    @(negedge clk);
    check("rdata (R2)", rdata, e_rd);
    check("cpu_irq (R6)", {27'd0, irq}, {27'd0, e_irq});
    check("hi_idx/vld (R7)", {2'd0, hvld, hidx}, {2'd0, e_vld, e_idx});
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a);
    addr = a;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tag = "R8"; rst = 1'b1; idle(3); rst = 1'b0;
    rd(5'd1); rd(5'd2);

    tag = "R4"; wr(5'd1, 32'h8040_0001); rd(5'd1);
    wr(5'd17, 32'hFFFF_FFFF); rd(5'd17);

    tag = "R1"; src[64+5] = 1'b1; step(); src = '0; rd(5'd8);
    tag = "R5"; rd(5'd10); wr(5'd9, 32'h0000_0020); rd(5'd10); idle(2);

    tag = "R6"; src[0] = 1'b1; src[22] = 1'b1; step(); src = '0; idle(2);
    tag = "R7"; rd(5'd2);

    tag = "R3"; wr(5'd0, 32'h0040_0000); idle(2); rd(5'd0);
    wr(5'd0, 32'h0000_0000); rd(5'd0);
    src[0] = 1'b1; wr(5'd0, 32'h0000_0001); src = '0; rd(5'd0);
    wr(5'd0, 32'h0000_0001); idle(2); rd(5'd0);

    tag = "R9"; wr(5'd3, 32'hFFFF_FFFF); rd(5'd3); wr(5'd7, 32'hFFFF_FFFF);
    wr(5'd20, 32'hFFFF_FFFF); wr(5'd29, 32'hFFFF_FFFF); rd(5'd20); rd(5'd31);
    rd(5'd1);

    tag = "R10"; src[96+3] = 1'b1; step(); src = '0;
    wr(5'd14, 32'hFFFF_FFFF); rd(5'd12); rd(5'd13);

    tag = "R7"; src[128+31] = 1'b1; src[128] = 1'b1; step(); src = '0; idle(2);
    wr(5'd16, 32'h8000_0000); idle(2);
    wr(5'd5, 32'h0000_0001); src[32] = 1'b1; step(); src = '0; idle(2);

    tag = "R2";
    for (int a = 0; a < 32; a++) rd(5'(a));

    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      for (int b = 0; b < 5; b++) src[b*32 +: 32] = $urandom & $urandom & $urandom;
      addr  = 5'($urandom_range(0, 31));
      wdata = $urandom;
      we    = ($urandom_range(0, 2) == 0);
      step();
    end
    we = 1'b0; src = '0;

    tag = "R8"; rst = 1'b1; idle(2); rst = 1'b0;
    rd(5'd1); rd(5'd17); rd(5'd0);
    finish_run();
  end
endmodule